// File: doc/BRIEF.md
# Shared Interrupt Line Aggregator

Several devices each present four level-sensitive interrupt pins. The block folds all of them onto four shared interrupt lines. Each pin is routed to a line by a rule that combines the slot number of its device with the pin index. The rotation spreads pin 0 of neighbouring devices across different lines.

The block does not OR a wide vector of pins on every cycle. It keeps one stored level per pin and, per line, a count of the pins currently asserted on it. A count moves only when a pin actually changes level. A line is driven high while its count is non-zero. The counts are also visible on a debug output.

The counts must stay consistent with the pins. If they do not, and an update would push a count below zero or above the number of devices, the count is clamped and a sticky fault flag is raised.

Top module: `irq_share_agg`

## Requirements
- R1: Pin p (0..3) of device d is carried at bit 4*d+p of `dev_pins`. It is routed to line (s+p) mod 4, where s is the device's slot taken from bits [SLOT_W*d +: SLOT_W] of `dev_slot`. Line l's count sits at bits [CNT_W*l +: CNT_W] of `line_count`, and its level at bit l of `line_out`.
- R2: A pin whose level equals its stored level changes no count. This holds even when the device's slot value changes in that cycle.
- R3: A pin seen at a clock edge going 0 to 1 adds one to its line's count, and going 1 to 0 subtracts one. The new count is visible right after that edge.
- R4: `line_out[l]` is 1 exactly when count l is non-zero. It changes at the same edge as the count.
- R5: Reset is asserted asynchronously and released on the clock. It clears all counts, lines, the fault flag and every stored pin level. Pins held high through reset are therefore counted as new rises once reset ends.
- R6: Several pins may change in one cycle. Each count then moves by the net number of rises minus falls routed to it, and a rise and a fall on the same line cancel.
- R7: A count never exceeds N_DEV. With every pin of every device high, each of the four counts equals N_DEV.
- R8: Suppose an update would take a count below zero, which a slot change while a pin is high can cause. The count is held at zero and `fault` goes high. `fault` stays high until reset, and other counts still update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_pins | input | 4*N_DEV | Pin levels, four per device |
| dev_slot | input | SLOT_W*N_DEV | Slot number per device, used for routing |
| line_out | output | 4 | Shared interrupt line levels |
| line_count | output | 4*CNT_W | Debug view of the per-line active counts |
| fault | output | 1 | Sticky flag for a clamped count |

## Verification
The situation hardest to reach is a count trying to go negative. With stable slots the counts always match the pins, so the bench has to create the inconsistency deliberately. It raises a pin, moves that device to another slot while the pin stays high, and then drops the pin so the fall lands on a line whose count is zero. A second hard case is checking that stored pin levels are really cleared by reset. For that, pins are held high through a mid-run reset, and the bench expects them to be counted again afterwards.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int PINS_PER_DEV = 4;
  localparam int NUM_LINES    = 4;
  localparam int LINE_W       = 2;

  typedef logic [LINE_W-1:0] line_idx_t;

  // Rotation of pin index by slot; wraps modulo NUM_LINES through width.
  function automatic line_idx_t route_line(input line_idx_t slot_lsb,
                                           input line_idx_t pin_idx);
    return slot_lsb + pin_idx;
  endfunction
endpackage

// File: rtl/irq_pin_tracker.sv
module irq_pin_tracker #(
  parameter int N_DEV = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_DEV*4-1:0]   pins_i,
  output logic [N_DEV*4-1:0]   rise_o,
  output logic [N_DEV*4-1:0]   fall_o,
  output logic [N_DEV*4-1:0]   state_o
);
  import irq_agg_pkg::*;

  for (genvar g = 0; g < N_DEV; g++) begin : g_dev
    logic [PINS_PER_DEV-1:0] cur_w;
    logic [PINS_PER_DEV-1:0] held_q;
    logic [PINS_PER_DEV-1:0] held_d;
    logic                    held_en;

    assign cur_w = pins_i[g*PINS_PER_DEV +: PINS_PER_DEV];

    always_comb begin
      held_en = (cur_w != held_q);
      held_d  = cur_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       held_q <= '0;
      else if (held_en) held_q <= held_d;
    end

    assign rise_o[g*PINS_PER_DEV +: PINS_PER_DEV]  = cur_w & ~held_q;
    assign fall_o[g*PINS_PER_DEV +: PINS_PER_DEV]  = ~cur_w & held_q;
    assign state_o[g*PINS_PER_DEV +: PINS_PER_DEV] = held_q;
  end
endmodule

// File: rtl/irq_line_router.sv
module irq_line_router #(
  parameter int N_DEV  = 8,
  parameter int SLOT_W = 5,
  parameter int CNT_W  = 4
) (
  input  logic [N_DEV*4-1:0]      rise_i,
  input  logic [N_DEV*4-1:0]      fall_i,
  input  logic [N_DEV*SLOT_W-1:0] slot_i,
  output logic [4*CNT_W-1:0]      up_o,
  output logic [4*CNT_W-1:0]      dn_o
);
  import irq_agg_pkg::*;

  logic [CNT_W-1:0] up_v [NUM_LINES];
  logic [CNT_W-1:0] dn_v [NUM_LINES];
  line_idx_t        ln;

  always_comb begin
    ln = '0;
    for (int l = 0; l < NUM_LINES; l++) begin
      up_v[l] = '0;
      dn_v[l] = '0;
    end
    for (int d = 0; d < N_DEV; d++) begin
      for (int p = 0; p < PINS_PER_DEV; p++) begin
        ln = route_line(slot_i[d*SLOT_W +: LINE_W], LINE_W'(p));
        if (rise_i[d*PINS_PER_DEV+p]) up_v[ln] = up_v[ln] + CNT_W'(1);
        if (fall_i[d*PINS_PER_DEV+p]) dn_v[ln] = dn_v[ln] + CNT_W'(1);
      end
    end
    for (int l = 0; l < NUM_LINES; l++) begin
      up_o[l*CNT_W +: CNT_W] = up_v[l];
      dn_o[l*CNT_W +: CNT_W] = dn_v[l];
    end
  end
endmodule

// File: rtl/irq_line_counter.sv
module irq_line_counter #(
  parameter int CNT_W   = 4,
  parameter int MAX_CNT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] up_i,
  input  logic [CNT_W-1:0] dn_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             line_o,
  output logic             bad_o
);
  logic [CNT_W:0]   sum_w;
  logic [CNT_W:0]   diff_w;
  logic             under_w;
  logic             over_w;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             line_q;
  logic             line_d;
  logic             upd_en;

  always_comb begin
    upd_en  = (up_i != '0) || (dn_i != '0);
    sum_w   = {1'b0, cnt_q} + {1'b0, up_i};
    under_w = sum_w < {1'b0, dn_i};
    diff_w  = sum_w - {1'b0, dn_i};
    over_w  = !under_w && (diff_w > (CNT_W+1)'(MAX_CNT));
    if (under_w)     cnt_d = '0;
    else if (over_w) cnt_d = CNT_W'(MAX_CNT);
    else             cnt_d = diff_w[CNT_W-1:0];
    line_d = (cnt_d != '0);
    bad_o  = upd_en && (under_w || over_w);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      line_q <= 1'b0;
    end else if (upd_en) begin
      cnt_q  <= cnt_d;
      line_q <= line_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign line_o = line_q;

  // R4: level register agrees with count register
  a_r4_line_matches_count: assert property (@(posedge clk) disable iff (!rst_n)
    line_o == (cnt_o != '0));

  // R7: count bounded by number of devices
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_o <= CNT_W'(MAX_CNT));
endmodule

// File: rtl/irq_share_agg.sv
module irq_share_agg #(
  parameter int N_DEV  = 8,
  parameter int SLOT_W = 5,
  localparam int CNT_W = $clog2(N_DEV + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_DEV*4-1:0]      dev_pins,
  input  logic [N_DEV*SLOT_W-1:0] dev_slot,
  output logic [3:0]              line_out,
  output logic [4*CNT_W-1:0]      line_count,
  output logic                    fault
);
  import irq_agg_pkg::*;

  // reset: asynchronous assertion, clocked release
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  logic [N_DEV*4-1:0] rise_w;
  logic [N_DEV*4-1:0] fall_w;
  logic [N_DEV*4-1:0] state_w;
  logic [4*CNT_W-1:0] up_w;
  logic [4*CNT_W-1:0] dn_w;
  logic [NUM_LINES-1:0] bad_w;

  irq_pin_tracker #(.N_DEV(N_DEV)) u_track (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .pins_i  (dev_pins),
    .rise_o  (rise_w),
    .fall_o  (fall_w),
    .state_o (state_w)
  );

  irq_line_router #(.N_DEV(N_DEV), .SLOT_W(SLOT_W), .CNT_W(CNT_W)) u_route (
    .rise_i (rise_w),
    .fall_i (fall_w),
    .slot_i (dev_slot),
    .up_o   (up_w),
    .dn_o   (dn_w)
  );

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    irq_line_counter #(.CNT_W(CNT_W), .MAX_CNT(N_DEV)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n_s),
      .up_i   (up_w[l*CNT_W +: CNT_W]),
      .dn_i   (dn_w[l*CNT_W +: CNT_W]),
      .cnt_o  (line_count[l*CNT_W +: CNT_W]),
      .line_o (line_out[l]),
      .bad_o  (bad_w[l])
    );
  end

  logic fault_q;
  logic fault_d;
  logic fault_en;

  always_comb begin
    fault_en = |bad_w;
    fault_d  = fault_q | fault_en;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)      fault_q <= 1'b0;
    else if (fault_en) fault_q <= fault_d;
  end
  assign fault = fault_q;

  // ---------------- assertions ----------------
  logic arm_q;
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) arm_q <= 1'b0;
    else          arm_q <= 1'b1;
  end

  int cnt_total;
  always_comb begin
    cnt_total = 0;
    for (int l = 0; l < NUM_LINES; l++)
      cnt_total += int'(line_count[l*CNT_W +: CNT_W]);
  end

  // R2: unchanged pins leave every count untouched
  a_r2_quiet_pins: assert property (@(posedge clk) disable iff (!rst_n_s)
    (arm_q && $stable(dev_pins)) |=> $stable(line_count));

  // R6: without a fault, counts add up to the number of stored high pins
  a_r6_conserved: assert property (@(posedge clk) disable iff (!rst_n_s)
    !fault |-> (cnt_total == $countones(state_w)));

  // R8: fault is sticky
  a_r8_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n_s)
    fault |=> fault);
endmodule

// File: tb/sim_irq_share_agg.sv
module sim_irq_share_agg;
  localparam int N_DEV  = 8;
  localparam int SLOT_W = 5;
  localparam int CNT_W  = $clog2(N_DEV + 1);
  localparam int NP     = N_DEV * 4;

  logic                    clk;
  logic                    rst_n;
  logic [NP-1:0]           dev_pins;
  logic [N_DEV*SLOT_W-1:0] dev_slot;
  logic [3:0]              line_out;
  logic [4*CNT_W-1:0]      line_count;
  logic                    fault;

  irq_share_agg #(.N_DEV(N_DEV), .SLOT_W(SLOT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .dev_pins(dev_pins), .dev_slot(dev_slot),
    .line_out(line_out), .line_count(line_count), .fault(fault)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct {
    logic [3:0]         lines;
    logic [4*CNT_W-1:0] counts;
    logic               flt;
    string              tag;
  } exp_t;

  exp_t q[$];
  int n_chk  = 0;
  int n_fail = 0;

  // reference model state
  logic [NP-1:0] m_pins;
  int            m_cnt [4];
  logic          m_fault;

  function automatic exp_t snapshot(string tag);
    exp_t e;
    e.tag = tag;
    e.flt = m_fault;
    for (int l = 0; l < 4; l++) begin
      e.counts[l*CNT_W +: CNT_W] = CNT_W'(m_cnt[l]);
      e.lines[l] = (m_cnt[l] != 0);
    end
    return e;
  endfunction

  task automatic model_reset();
    m_pins  = '0;
    m_fault = 1'b0;
    for (int l = 0; l < 4; l++) m_cnt[l] = 0;
  endtask

  task automatic apply(input logic [NP-1:0] pins,
                       input logic [N_DEV*SLOT_W-1:0] slots, input string tag);
    int up [4];
    int dn [4];
    @(negedge clk);
    dev_pins = pins;
    dev_slot = slots;
    for (int l = 0; l < 4; l++) begin up[l] = 0; dn[l] = 0; end
    for (int d = 0; d < N_DEV; d++)
      for (int p = 0; p < 4; p++)
        if (pins[4*d+p] != m_pins[4*d+p]) begin
          int ln;
          ln = (int'(slots[d*SLOT_W +: SLOT_W]) + p) % 4;
          if (pins[4*d+p]) up[ln]++; else dn[ln]++;
        end
    for (int l = 0; l < 4; l++) begin
      int v;
      v = m_cnt[l] + up[l] - dn[l];
      if (v < 0)          begin v = 0;     m_fault = 1'b1; end
      else if (v > N_DEV) begin v = N_DEV; m_fault = 1'b1; end
      m_cnt[l] = v;
    end
    m_pins = pins;
    q.push_back(snapshot(tag));
  endtask

  // monitor: compares one expected item per cycle after the update edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_chk++;
        if (line_out !== e.lines || line_count !== e.counts || fault !== e.flt) begin
          n_fail++;
          $display("FAIL %s: got lines=%b counts=%h fault=%b, expected lines=%b counts=%h fault=%b",
                   e.tag, line_out, line_count, fault, e.lines, e.counts, e.flt);
        end
      end
    end
  end

  task automatic direct_check(input string tag);
    exp_t e;
    e = snapshot(tag);
    n_chk++;
    if (line_out !== e.lines || line_count !== e.counts || fault !== e.flt) begin
      n_fail++;
      $display("FAIL %s: got lines=%b counts=%h fault=%b, expected lines=%b counts=%h fault=%b",
               tag, line_out, line_count, fault, e.lines, e.counts, e.flt);
    end
  endtask

  task automatic drain();
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic logic [NP-1:0] pin_bit(int d, int p);
    logic [NP-1:0] v;
    v = '0;
    v[4*d+p] = 1'b1;
    return v;
  endfunction

  logic [N_DEV*SLOT_W-1:0] s0;
  logic [N_DEV*SLOT_W-1:0] s1;
  logic [NP-1:0] pv;

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    for (int d = 0; d < N_DEV; d++) s0[d*SLOT_W +: SLOT_W] = SLOT_W'(d);
    rst_n    = 1'b0;
    dev_pins = '0;
    dev_slot = s0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    direct_check("R5 reset state");

    // R1 R3 R4: device 0 pin 0, slot 0 -> line 0
    pv = pin_bit(0, 0);
    apply(pv, s0, "R1 R3 R4 single rise");
    // R2: same levels again
    apply(pv, s0, "R2 repeat level");
    // R1: device 1 pin 2, slot 1 -> line 3
    pv = pv | pin_bit(1, 2);
    apply(pv, s0, "R1 routing slot+pin");
    // R3: fall of device 0 pin 0
    pv = pv & ~pin_bit(0, 0);
    apply(pv, s0, "R3 single fall");
    // R6: device 2 pins 0,1 rise (lines 2,3), device 1 pin 2 falls (line 3)
    pv = pin_bit(2, 0) | pin_bit(2, 1);
    apply(pv, s0, "R6 simultaneous net");
    // R6: rise and fall on the same line cancel (dev 0 pin 3 -> line 3, dev 2 pin 1 falls from line 3)
    pv = pin_bit(2, 0) | pin_bit(0, 3);
    apply(pv, s0, "R6 cancel on one line");
    // R7: everything high
    apply('1, s0, "R7 all pins high");
    apply('1, s0, "R7 hold full");
    apply('0, s0, "R6 all fall together");
    // random patterns with fixed slots
    for (int i = 0; i < 40; i++) apply(NP'($urandom), s0, "R6 random pattern");
    apply('0, s0, "R3 clear");
    drain();

    // R8: drive a count negative through a slot move
    s1 = s0;
    s1[0 +: SLOT_W] = SLOT_W'(1);
    apply(pin_bit(0, 0), s0, "R8 setup rise line0");
    apply(pin_bit(0, 0), s1, "R2 slot change only");
    apply('0, s1, "R8 fall onto empty line");
    apply(pin_bit(3, 2), s1, "R8 fault sticky");
    apply('0, s1, "R8 fault still set");
    drain();

    // R5: mid-run reset with pins held high
    pv = pin_bit(1, 0) | pin_bit(4, 1) | pin_bit(5, 3);
    apply(pv, s0, "R3 pre-reset load");
    drain();
    dev_pins = pv;
    rst_n = 1'b0;
    #1;
    model_reset();
    direct_check("R5 async clear");
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    apply(pv, s0, "R5 held pins recounted");
    drain();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule